// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits between a set of requesting agents and a small shared word memory and gives each agent four operations: a plain load, a plain store, a load-linked (LL) and a store-conditional (SC). For each agent it keeps one reservation, made of a valid bit and a word address. An LL returns the memory word and arms that agent's reservation on the address. A later SC to the same address writes memory only if no other agent's write has reached that word in between. The agent gets back a one-bit condition flag that says whether the SC took effect.

A fixed-priority arbiter gives the single memory port to one request per cycle, with the lowest agent index winning. Some SCs are sure to fail: those whose reservation was cleared by another writer, was never set, or points at a different word. These are answered directly without using the memory port, so they never touch memory and never raise an invalidation. Each successful write drives a one-cycle invalidate pulse that carries the written address, and a running counter totals these pulses. The pulse and the counter stand in for the coherence traffic a real cache hierarchy would produce.

An agent raises `req_valid` with an operation code, an address and write data, and holds them until it sees `resp_valid`. It then drops the request in the same cycle. Operation codes: 0 load, 1 store, 2 LL, 3 SC.

Top module: `llsc_monitor`

## Requirements
- R1: A load or an LL returns, on `resp_rdata`, the memory word at the requested address, with the response raised one cycle after the grant.
- R2: An SC whose agent holds a valid reservation on that same address, with no other agent's write to it since the LL, writes its data to memory and reports `resp_flag` = 1.
- R3: `resp_flag` is 1 only for a successful SC. For a load, a store, an LL or a failed SC it is 0.
- R4: A failed SC leaves memory unchanged and produces no invalidate pulse.
- R5: An SC with no usable reservation is answered one cycle after it is presented, with flag 0. This holds even while another agent holds the memory grant in that cycle.
- R6: When two agents present SCs to the same reserved address in the same cycle, the lower-index agent succeeds. The other fails, because the winner's write clears its reservation.
- R7: A successful store or SC clears the reservation of every other agent that holds that address. Reservations on other addresses survive.
- R8: An agent's new LL replaces its earlier reservation. Any SC by that agent, whether it succeeds or fails, clears its reservation, so a second SC without a new LL fails.
- R9: An SC from an agent that has never issued an LL fails.
- R10: Each successful write raises `inval_pulse` for one cycle, together with the response, with the written address on `inval_addr`. `inval_count` increases by one with each pulse.
- R11: At most one request is granted per cycle, and the lowest-index eligible agent wins. An agent whose response is being returned in a cycle is not eligible in that cycle.
- R12: After reset there are no responses, no reservations, every memory word reads 0 and `inval_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_AGENTS | Per-agent request strobe, held until the response |
| req_op | input | 2*N_AGENTS | Per-agent operation code (0 load, 1 store, 2 LL, 3 SC) |
| req_addr | input | ADDR_W*N_AGENTS | Per-agent word address |
| req_wdata | input | DATA_W*N_AGENTS | Per-agent write data for store and SC |
| resp_valid | output | N_AGENTS | Per-agent one-cycle response strobe |
| resp_rdata | output | DATA_W*N_AGENTS | Per-agent read data for load and LL |
| resp_flag | output | N_AGENTS | Per-agent SC success flag |
| inval_pulse | output | 1 | One-cycle pulse per successful write |
| inval_addr | output | ADDR_W | Address of the write that raised the pulse |
| inval_count | output | CNT_W | Running total of invalidate pulses |

## Verification
The embedded properties take for granted that each agent keeps `req_valid` and its fields steady until its response, and drops the request in the response cycle. They also assume no agent presents a new request in the cycle its own response appears. The bench drives every request at the falling edge and waits for the matching `resp_valid`. It clears the request at the same falling edge where it samples the response, so the request handshake never breaks these assumptions. The deliberate collisions, a same-cycle SC race and an SC that fails while a load holds the port, are built from the same handshake and only line up the start cycle.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_LINK  = 2'd2,
        OP_COND  = 2'd3
    } llsc_op_e;

endpackage

// File: rtl/llsc_arbiter.sv
module llsc_arbiter #(
    parameter int N_AGENTS = 4,
    localparam int IDX_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_AGENTS-1:0] req,
    output logic [N_AGENTS-1:0] grant,
    output logic                grant_any,
    output logic [IDX_W-1:0]    grant_idx
);

    always_comb begin
        logic found;
        found     = 1'b0;
        grant     = '0;
        grant_idx = '0;
        for (int i = 0; i < N_AGENTS; i++) begin
            if (req[i] && !found) begin
                grant[i]  = 1'b1;
                grant_idx = IDX_W'(i);
                found     = 1'b1;
            end
        end
        grant_any = found;
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)) else $error("more than one grant"); // R11

    AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> (((grant - 1'b1) & req) == '0)) else $error("priority broken"); // R11

    AST_NO_IDLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> (grant != '0)) else $error("request left idle"); // R11

endmodule

// File: rtl/llsc_resv_table.sv
module llsc_resv_table #(
    parameter int N_AGENTS = 4,
    parameter int ADDR_W   = 6
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [N_AGENTS-1:0]              set_vec,
    input  logic [N_AGENTS-1:0]              clr_vec,
    input  logic [ADDR_W-1:0]                set_addr,
    input  logic                             wr_fire,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [N_AGENTS-1:0]              wr_owner,
    output logic [N_AGENTS-1:0]              resv_valid,
    output logic [N_AGENTS-1:0][ADDR_W-1:0]  resv_addr
);

    typedef struct packed {
        logic [N_AGENTS-1:0]             vld;
        logic [N_AGENTS-1:0][ADDR_W-1:0] addr;
    } resv_t;

    resv_t tab_d, tab_q;

    always_comb begin
        tab_d = tab_q;
        for (int i = 0; i < N_AGENTS; i++) begin
            if (set_vec[i]) begin
                tab_d.vld[i]  = 1'b1;
                tab_d.addr[i] = set_addr;
            end else if (clr_vec[i]) begin
                tab_d.vld[i]  = 1'b0;
            end else if (wr_fire && !wr_owner[i] && tab_q.vld[i]
                         && (tab_q.addr[i] == wr_addr)) begin
                tab_d.vld[i]  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tab_q <= '0;
        end else begin
            tab_q <= tab_d;
        end
    end

    assign resv_valid = tab_q.vld;
    assign resv_addr  = tab_q.addr;

    for (genvar g = 0; g < N_AGENTS; g++) begin : g_chk
        AST_SNOOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_fire && !wr_owner[g] && !set_vec[g] && resv_valid[g]
             && (resv_addr[g] == wr_addr)) |=> !resv_valid[g])
            else $error("reservation survived a foreign write"); // R7

        AST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[g] && !set_vec[g]) |=> !resv_valid[g])
            else $error("reservation survived own SC"); // R8

        AST_LINK_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[g] |=> (resv_valid[g] && resv_addr[g] == $past(set_addr)))
            else $error("LL did not arm reservation"); // R1
    end

endmodule

// File: rtl/llsc_mem.sv
module llsc_mem #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              we,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);

    logic [DEPTH-1:0][DATA_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_addr];

    AST_NO_SPURIOUS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(mem_q)) else $error("memory changed without write"); // R4

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem_q[$past(wr_addr)] == $past(wr_data))) else $error("write lost"); // R2

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
    parameter int N_AGENTS = 4,
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_AGENTS-1:0]          req_valid,
    input  logic [2*N_AGENTS-1:0]        req_op,
    input  logic [ADDR_W*N_AGENTS-1:0]   req_addr,
    input  logic [DATA_W*N_AGENTS-1:0]   req_wdata,
    output logic [N_AGENTS-1:0]          resp_valid,
    output logic [DATA_W*N_AGENTS-1:0]   resp_rdata,
    output logic [N_AGENTS-1:0]          resp_flag,
    output logic                         inval_pulse,
    output logic [ADDR_W-1:0]            inval_addr,
    output logic [CNT_W-1:0]             inval_count
);

    import llsc_pkg::*;

    localparam int IDX_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1;

    typedef struct packed {
        logic [N_AGENTS-1:0]             rvld;
        logic [N_AGENTS-1:0]             flag;
        logic [N_AGENTS-1:0][DATA_W-1:0] rdata;
        logic                            inval;
        logic [ADDR_W-1:0]               iaddr;
        logic [CNT_W-1:0]                cnt;
    } mon_t;

    mon_t st_d, st_q;

    llsc_op_e                         op_a   [N_AGENTS];
    logic [N_AGENTS-1:0][ADDR_W-1:0]  addr_a;
    logic [N_AGENTS-1:0][DATA_W-1:0]  wdat_a;

    logic [N_AGENTS-1:0]              fast_fail;
    logic [N_AGENTS-1:0]              arb_req;
    logic [N_AGENTS-1:0]              grant;
    logic                             grant_any;
    logic [IDX_W-1:0]                 grant_idx;

    llsc_op_e                         g_op;
    logic [ADDR_W-1:0]                g_addr;
    logic [DATA_W-1:0]                g_wdata;
    logic                             mem_we;
    logic [DATA_W-1:0]                mem_rdata;

    logic [N_AGENTS-1:0]              resv_valid;
    logic [N_AGENTS-1:0][ADDR_W-1:0]  resv_addr;
    logic [N_AGENTS-1:0]              set_vec;
    logic [N_AGENTS-1:0]              clr_vec;

    for (genvar g = 0; g < N_AGENTS; g++) begin : g_unpack
        assign op_a[g]   = llsc_op_e'(req_op[2*g +: 2]);
        assign addr_a[g] = req_addr[ADDR_W*g +: ADDR_W];
        assign wdat_a[g] = req_wdata[DATA_W*g +: DATA_W];
        assign fast_fail[g] = req_valid[g] && !st_q.rvld[g] && (op_a[g] == OP_COND)
                              && !(resv_valid[g] && (resv_addr[g] == addr_a[g]));
    end

    assign arb_req = req_valid & ~st_q.rvld & ~fast_fail;

    llsc_arbiter #(.N_AGENTS(N_AGENTS)) arb_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (arb_req),
        .grant     (grant),
        .grant_any (grant_any),
        .grant_idx (grant_idx)
    );

    always_comb begin
        g_op    = op_a[grant_idx];
        g_addr  = addr_a[grant_idx];
        g_wdata = wdat_a[grant_idx];
        mem_we  = grant_any && ((g_op == OP_STORE) || (g_op == OP_COND));
        set_vec = grant & {N_AGENTS{g_op == OP_LINK}};
        clr_vec = (grant & {N_AGENTS{g_op == OP_COND}}) | fast_fail;
    end

    llsc_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) mem_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (g_addr),
        .rd_data (mem_rdata),
        .we      (mem_we),
        .wr_addr (g_addr),
        .wr_data (g_wdata)
    );

    llsc_resv_table #(.N_AGENTS(N_AGENTS), .ADDR_W(ADDR_W)) resv_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_vec    (set_vec),
        .clr_vec    (clr_vec),
        .set_addr   (g_addr),
        .wr_fire    (mem_we),
        .wr_addr    (g_addr),
        .wr_owner   (grant),
        .resv_valid (resv_valid),
        .resv_addr  (resv_addr)
    );

    always_comb begin
        st_d       = st_q;
        st_d.rvld  = grant | fast_fail;
        st_d.flag  = grant & {N_AGENTS{g_op == OP_COND}};
        for (int i = 0; i < N_AGENTS; i++) begin
            if (grant[i]) begin
                st_d.rdata[i] = mem_rdata;
            end
        end
        st_d.inval = mem_we;
        if (mem_we) begin
            st_d.iaddr = g_addr;
            st_d.cnt   = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign resp_valid  = st_q.rvld;
    assign resp_flag   = st_q.flag;
    assign resp_rdata  = st_q.rdata;
    assign inval_pulse = st_q.inval;
    assign inval_addr  = st_q.iaddr;
    assign inval_count = st_q.cnt;

    AST_RESP_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        grant_any |=> ((resp_valid & $past(grant)) == $past(grant)))
        else $error("granted agent got no response"); // R11

    AST_FAST_FAIL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_fail != '0) |=> ((resp_valid & resp_flag & $past(fast_fail)) == '0))
        else $error("fast-failed SC reported success"); // R5

    AST_NO_GRANT_NO_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_any |=> !inval_pulse) else $error("invalidate without a write"); // R4

    AST_INVAL_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        inval_pulse |-> (inval_count == $past(inval_count) + 1'b1))
        else $error("counter missed a pulse"); // R10

    AST_FLAG_WITH_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        ((resp_flag & ~resp_valid) == '0)) else $error("flag without response"); // R3

endmodule

// File: tb/llsc_monitor_tb.sv
module llsc_monitor_tb_top;

    localparam int NA = 4;
    localparam int AW = 6;
    localparam int DW = 32;
    localparam int CW = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NA-1:0]     req_valid = '0;
    logic [2*NA-1:0]   req_op = '0;
    logic [AW*NA-1:0]  req_addr = '0;
    logic [DW*NA-1:0]  req_wdata = '0;
    logic [NA-1:0]     resp_valid;
    logic [DW*NA-1:0]  resp_rdata;
    logic [NA-1:0]     resp_flag;
    logic              inval_pulse;
    logic [AW-1:0]     inval_addr;
    logic [CW-1:0]     inval_count;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_cnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    llsc_monitor #(.N_AGENTS(NA), .ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .resp_valid(resp_valid),
        .resp_rdata(resp_rdata), .resp_flag(resp_flag), .inval_pulse(inval_pulse),
        .inval_addr(inval_addr), .inval_count(inval_count)
    );

    typedef struct packed {
        logic [1:0]  ag;
        logic [1:0]  op;
        logic [5:0]  addr;
        logic [31:0] wd;
        logic        ef;
        logic        chk;
        logic [31:0] erd;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 2'd1, 6'd5,  32'hAA, 1'b0, 1'b0, 32'h0 },  // store
        '{2'd1, 2'd0, 6'd5,  32'h0,  1'b0, 1'b1, 32'hAA},  // R1 load
        '{2'd2, 2'd2, 6'd5,  32'h0,  1'b0, 1'b1, 32'hAA},  // R1 LL
        '{2'd2, 2'd3, 6'd5,  32'hBB, 1'b1, 1'b0, 32'h0 },  // R2 SC ok
        '{2'd3, 2'd0, 6'd5,  32'h0,  1'b0, 1'b1, 32'hBB},  // R2 written
        '{2'd2, 2'd3, 6'd5,  32'hCC, 1'b0, 1'b0, 32'h0 },  // R8 second SC fails
        '{2'd3, 2'd0, 6'd5,  32'h0,  1'b0, 1'b1, 32'hBB},  // R4 no write
        '{2'd1, 2'd3, 6'd7,  32'h11, 1'b0, 1'b0, 32'h0 },  // R9 no LL
        '{2'd1, 2'd2, 6'd7,  32'h0,  1'b0, 1'b1, 32'h0 },  // LL
        '{2'd0, 2'd1, 6'd7,  32'h22, 1'b0, 1'b0, 32'h0 },  // foreign store
        '{2'd1, 2'd3, 6'd7,  32'h33, 1'b0, 1'b0, 32'h0 },  // R7 cleared
        '{2'd1, 2'd0, 6'd7,  32'h0,  1'b0, 1'b1, 32'h22},  // R4 kept
        '{2'd1, 2'd2, 6'd9,  32'h0,  1'b0, 1'b1, 32'h0 },  // LL old
        '{2'd1, 2'd2, 6'd10, 32'h0,  1'b0, 1'b1, 32'h0 },  // R8 replace
        '{2'd0, 2'd1, 6'd9,  32'h44, 1'b0, 1'b0, 32'h0 },  // write old addr
        '{2'd1, 2'd3, 6'd10, 32'h55, 1'b1, 1'b0, 32'h0 },  // R8 new resv wins
        '{2'd2, 2'd0, 6'd10, 32'h0,  1'b0, 1'b1, 32'h55},
        '{2'd3, 2'd2, 6'd12, 32'h0,  1'b0, 1'b1, 32'h0 },
        '{2'd0, 2'd1, 6'd13, 32'h66, 1'b0, 1'b0, 32'h0 },  // R7 other addr
        '{2'd3, 2'd3, 6'd12, 32'h77, 1'b1, 1'b0, 32'h0 }   // R7 survives
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input int a, input logic [1:0] op, input logic [5:0] addr,
                         input logic [31:0] wd);
        req_valid[a]          = 1'b1;
        req_op[2*a +: 2]      = op;
        req_addr[AW*a +: AW]  = addr;
        req_wdata[DW*a +: DW] = wd;
    endtask

    task automatic do_op(input int a, input logic [1:0] op, input logic [5:0] addr,
                         input logic [31:0] wd, output logic [31:0] rd, output logic fl,
                         output logic pl, output logic [5:0] pa, output int lat);
        @(negedge clk);
        drive(a, op, addr, wd);
        lat = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            lat++;
            if (resp_valid[a]) break;
        end
        rd = resp_rdata[DW*a +: DW];
        fl = resp_flag[a];
        pl = inval_pulse;
        pa = inval_addr;
        req_valid[a] = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic fl, pl;
        logic [5:0] pa;
        int lat;

        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 resp_valid in reset", 32'(resp_valid), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 resp_valid after reset", 32'(resp_valid), 32'h0);
        check("R12 inval_count after reset", 32'(inval_count), 32'h0);
        check("R12 inval_pulse after reset", 32'(inval_pulse), 32'h0);
        do_op(0, 2'd0, 6'd3, 32'h0, rd, fl, pl, pa, lat);
        check("R12 memory cleared", rd, 32'h0);
        do_op(0, 2'd3, 6'd3, 32'h9, rd, fl, pl, pa, lat);
        check("R12 no reservation after reset", 32'(fl), 32'h0);

        // table walk: R1 R2 R3 R4 R7 R8 R9 R10
        for (int v = 0; v < NV; v++) begin
            logic exp_pl;
            do_op(int'(VEC[v].ag), VEC[v].op, VEC[v].addr, VEC[v].wd, rd, fl, pl, pa, lat);
            exp_pl = (VEC[v].op == 2'd1) || (VEC[v].op == 2'd3 && VEC[v].ef);
            if (exp_pl) exp_cnt++;
            check($sformatf("R11 latency vec %0d", v), 32'(lat), 32'd1);
            check($sformatf("R3 flag vec %0d", v), 32'(fl), 32'(VEC[v].ef));
            check($sformatf("R10 pulse vec %0d", v), 32'(pl), 32'(exp_pl));
            if (exp_pl) check($sformatf("R10 inval_addr vec %0d", v), 32'(pa), 32'(VEC[v].addr));
            if (VEC[v].chk) check($sformatf("R1 rdata vec %0d", v), rd, VEC[v].erd);
        end
        check("R10 inval_count after table", 32'(inval_count), 32'(exp_cnt));

        // R6 same-cycle SC race on address 20
        do_op(1, 2'd2, 6'd20, 32'h0, rd, fl, pl, pa, lat);
        do_op(2, 2'd2, 6'd20, 32'h0, rd, fl, pl, pa, lat);
        @(negedge clk);
        drive(1, 2'd3, 6'd20, 32'hA1);
        drive(2, 2'd3, 6'd20, 32'hA2);
        @(negedge clk);
        check("R6 winner responds", 32'(resp_valid), 32'b0010);
        check("R6 winner flag", 32'(resp_flag[1]), 32'h1);
        check("R10 race pulse", 32'(inval_pulse), 32'h1);
        exp_cnt++;
        req_valid[1] = 1'b0;
        @(negedge clk);
        check("R6 loser responds", 32'(resp_valid), 32'b0100);
        check("R6 loser flag", 32'(resp_flag[2]), 32'h0);
        check("R4 loser no pulse", 32'(inval_pulse), 32'h0);
        req_valid[2] = 1'b0;
        do_op(3, 2'd0, 6'd20, 32'h0, rd, fl, pl, pa, lat);
        check("R6 memory holds winner data", rd, 32'hA1);

        // R5 fast fail while agent 0 holds the port
        do_op(3, 2'd2, 6'd30, 32'h0, rd, fl, pl, pa, lat);
        do_op(0, 2'd1, 6'd30, 32'h5, rd, fl, pl, pa, lat);
        exp_cnt++;
        @(negedge clk);
        drive(0, 2'd0, 6'd31, 32'h0);
        drive(3, 2'd3, 6'd30, 32'hEE);
        @(negedge clk);
        check("R5 both answered together", 32'(resp_valid), 32'b1001);
        check("R5 fast fail flag", 32'(resp_flag[3]), 32'h0);
        check("R4 fast fail no pulse", 32'(inval_pulse), 32'h0);
        req_valid[0] = 1'b0;
        req_valid[3] = 1'b0;
        do_op(1, 2'd0, 6'd30, 32'h0, rd, fl, pl, pa, lat);
        check("R4 fast fail left memory", rd, 32'h5);

        // R11 fixed priority between two loads
        @(negedge clk);
        drive(2, 2'd0, 6'd5, 32'h0);
        drive(3, 2'd0, 6'd10, 32'h0);
        @(negedge clk);
        check("R11 lower index first", 32'(resp_valid), 32'b0100);
        check("R1 agent 2 data", resp_rdata[DW*2 +: DW], 32'hBB);
        req_valid[2] = 1'b0;
        @(negedge clk);
        check("R11 higher index next", 32'(resp_valid), 32'b1000);
        check("R1 agent 3 data", resp_rdata[DW*3 +: DW], 32'h55);
        req_valid[3] = 1'b0;

        @(negedge clk);
        check("R10 final inval_count", 32'(inval_count), 32'(exp_cnt));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule